// File: doc/BRIEF.md
# Dual-Bank Paired Register File

This block is the programmer-visible register storage of an 8-bit processor core. It holds three general-purpose register pairs and an accumulator/flag pair, all duplicated into a main bank and an alternate bank. It also holds two standalone byte registers and four standalone 16-bit registers. In total this is 208 bits: eighteen byte registers and four wide registers. All storage is static flip-flops with no reset, so contents persist for as long as the clock is held.

Every general-purpose byte can be reached one at a time through either of two byte read ports. The same byte can also be reached together with its partner through the 16-bit pair read port. One write port stores either a single byte or a whole pair in one clock. Two exchange inputs flip the active bank independently: one flips the bank used for all general pairs, and the other flips the bank used for the accumulator/flag pair. Instruction decoding, arithmetic and flag generation sit outside this block.

Top module: `regfile_dual_bank`

## Requirements
- R1: A synchronous reset makes the main bank (select 0) active for both the general pairs and the accumulator/flag pair. Register contents are not cleared by reset.
- R2: The byte address map is as follows. Addresses 0 to 5 select the general registers of the active general bank: the even address is the high byte and the following odd address is the low byte of pair address/2. Address 6 selects the accumulator and 7 the flag register of the active accumulator/flag bank. Addresses 8 and 9 select the two standalone bytes. Read ports A and B are combinational and independent of each other.
- R3: Byte addresses 10 to 15 read as zero, and a byte write to them changes no register.
- R4: The pair read port uses a 3-bit address. Addresses 0 to 2 return {high, low} of a general pair. Address 3 returns {accumulator, flag}. Addresses 4 to 7 return wide registers 0 to 3.
- R5: A pair write (wr_pair=1) stores wr_data[15:8] in the high byte and wr_data[7:0] in the low byte in the same clock edge, using pair address wr_addr[2:0].
- R6: A byte write (wr_pair=0) stores wr_data[7:0] into one byte and leaves its partner byte unchanged.
- R7: A pulse on xchg_gp flips the active bank of all three general pairs from the next edge onward. The accumulator and flag are not affected.
- R8: A pulse on xchg_af flips the active accumulator/flag bank from the next edge onward. The general pairs are not affected.
- R9: Reads are not bypassed. A read in the same cycle as a bank flip sees the old bank, and a read of a register being written returns its old value.
- R10: A write in the same cycle as a bank flip goes to the bank that was active before the flip.
- R11: With no write and no exchange, every register holds its value across clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset of the bank selects |
| xchg_gp | input | 1 | Flip the active general-pair bank |
| xchg_af | input | 1 | Flip the active accumulator/flag bank |
| we | input | 1 | Write enable |
| wr_pair | input | 1 | 1: pair write, 0: byte write |
| wr_addr | input | 4 | Byte address, or pair address in bits [2:0] |
| wr_data | input | 16 | Write data; byte writes use bits [7:0] |
| rd_a_addr | input | 4 | Byte read port A address |
| rd_a_data | output | 8 | Byte read port A data |
| rd_b_addr | input | 4 | Byte read port B address |
| rd_b_data | output | 8 | Byte read port B data |
| rd_p_addr | input | 3 | Pair read port address |
| rd_p_data | output | 16 | Pair read port data |

## Verification
On every clock, the assertions check the following: the bank selects return to the main bank after reset, each exchange input flips only its own select, a general pair write lands in both bytes at once, the active view stays fixed when nothing is written or exchanged, and unmapped byte addresses read zero. Other behaviours can only be shown by the bench's scenarios. These are the old value returned during a swap or write cycle, the bank that receives a write issued together with a swap, partner bytes surviving a byte write, and writes to unmapped addresses leaving all storage alone. The bench shows them by comparing all byte and pair addresses against an independent model after each scenario.

// File: rtl/rf_pkg.sv
package rf_pkg;
   typedef enum logic {BANK_MAIN = 1'b0, BANK_ALT = 1'b1} bank_e;

   localparam int unsigned NUM_BANKS = 2;

   function automatic int bank_slots(input int pairs);
      return 2 * pairs + 2;
   endfunction
endpackage

// File: rtl/rf_bank_sel.sv
module rf_bank_sel
   import rf_pkg::*;
(
   input  logic  clk,
   input  logic  rst,
   input  logic  xchg_gp,
   input  logic  xchg_af,
   output bank_e gp_sel,
   output bank_e af_sel
);
   logic [1:0] flip;
   bank_e      sel_q [2];

   assign flip = {xchg_af, xchg_gp};

   for (genvar g = 0; g < 2; g++) begin : g_sel
      always_ff @(posedge clk) begin
         if (rst)          sel_q[g] <= BANK_MAIN;
         else if (flip[g]) sel_q[g] <= (sel_q[g] == BANK_MAIN) ? BANK_ALT : BANK_MAIN;
      end
   end

   assign gp_sel = sel_q[0];
   assign af_sel = sel_q[1];
endmodule

// File: rtl/rf_bank.sv
module rf_bank #(
   parameter int DATA_W = 8,
   parameter int SLOTS  = 8
) (
   input  logic                           clk,
   input  logic [SLOTS-1:0]               slot_we,
   input  logic [SLOTS-1:0][DATA_W-1:0]   slot_wd,
   output logic [SLOTS-1:0][DATA_W-1:0]   slot_q
);
   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      logic [DATA_W-1:0] r;
      always_ff @(posedge clk) begin
         if (slot_we[s]) r <= slot_wd[s];
      end
      assign slot_q[s] = r;
   end
endmodule

// File: rtl/rf_misc_file.sv
module rf_misc_file #(
   parameter int DATA_W    = 8,
   parameter int AUX_BYTES = 2,
   parameter int WIDE_REGS = 4,
   localparam int PW       = 2 * DATA_W
) (
   input  logic                              clk,
   input  logic [AUX_BYTES-1:0]              aux_we,
   input  logic [DATA_W-1:0]                 aux_wd,
   output logic [AUX_BYTES-1:0][DATA_W-1:0]  aux_q,
   input  logic [WIDE_REGS-1:0]              wide_we,
   input  logic [PW-1:0]                     wide_wd,
   output logic [WIDE_REGS-1:0][PW-1:0]      wide_q
);
   for (genvar a = 0; a < AUX_BYTES; a++) begin : g_aux
      logic [DATA_W-1:0] r;
      always_ff @(posedge clk) begin
         if (aux_we[a]) r <= aux_wd;
      end
      assign aux_q[a] = r;
   end

   for (genvar w = 0; w < WIDE_REGS; w++) begin : g_wide
      logic [PW-1:0] r;
      always_ff @(posedge clk) begin
         if (wide_we[w]) r <= wide_wd;
      end
      assign wide_q[w] = r;
   end
endmodule

// File: rtl/regfile_dual_bank.sv
module regfile_dual_bank
   import rf_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int GP_PAIRS   = 3,
   parameter int WIDE_REGS  = 4,
   parameter int AUX_BYTES  = 2,
   localparam int BANK_SLOTS = bank_slots(GP_PAIRS),
   localparam int BYTE_SLOTS = BANK_SLOTS + AUX_BYTES,
   localparam int PAIR_SLOTS = GP_PAIRS + 1 + WIDE_REGS,
   localparam int BA_W       = $clog2(BYTE_SLOTS),
   localparam int PA_W       = $clog2(PAIR_SLOTS),
   localparam int PW         = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              xchg_gp,
   input  logic              xchg_af,
   input  logic              we,
   input  logic              wr_pair,
   input  logic [BA_W-1:0]   wr_addr,
   input  logic [PW-1:0]     wr_data,
   input  logic [BA_W-1:0]   rd_a_addr,
   output logic [DATA_W-1:0] rd_a_data,
   input  logic [BA_W-1:0]   rd_b_addr,
   output logic [DATA_W-1:0] rd_b_data,
   input  logic [PA_W-1:0]   rd_p_addr,
   output logic [PW-1:0]     rd_p_data
);
   localparam int N_GP = 2 * GP_PAIRS;

   // elaboration-time parameter checks
   if (DATA_W < 1)    begin : g_bad_width  $error("DATA_W must be at least 1");    end
   if (GP_PAIRS < 1)  begin : g_bad_pairs  $error("GP_PAIRS must be at least 1");  end
   if (WIDE_REGS < 1) begin : g_bad_wide   $error("WIDE_REGS must be at least 1"); end
   if (AUX_BYTES < 1) begin : g_bad_aux    $error("AUX_BYTES must be at least 1"); end
   if (PA_W > BA_W)   begin : g_bad_addr   $error("pair address wider than byte address"); end

   bank_e gp_sel, af_sel;

   logic [BANK_SLOTS-1:0]                        slot_we;
   logic [BANK_SLOTS-1:0][DATA_W-1:0]            slot_wd;
   logic [NUM_BANKS-1:0][BANK_SLOTS-1:0]         bank_we;
   logic [NUM_BANKS-1:0][BANK_SLOTS-1:0][DATA_W-1:0] bank_q;
   logic [AUX_BYTES-1:0]                         aux_we;
   logic [AUX_BYTES-1:0][DATA_W-1:0]             aux_q;
   logic [WIDE_REGS-1:0]                         wide_we;
   logic [WIDE_REGS-1:0][PW-1:0]                 wide_q;
   logic [BYTE_SLOTS-1:0][DATA_W-1:0]            act_bytes;
   logic [PA_W-1:0]                              wr_pa;

   assign wr_pa = wr_addr[PA_W-1:0];

   rf_bank_sel u_sel (
      .clk     (clk),
      .rst     (rst),
      .xchg_gp (xchg_gp),
      .xchg_af (xchg_af),
      .gp_sel  (gp_sel),
      .af_sel  (af_sel)
   );

   // write decode: slot enables and slot data, bank-independent
   always_comb begin
      slot_we = '0;
      aux_we  = '0;
      wide_we = '0;
      for (int s = 0; s < BANK_SLOTS; s++) slot_wd[s] = wr_data[DATA_W-1:0];
      if (we && !wr_pair) begin
         for (int s = 0; s < BANK_SLOTS; s++)
            if (int'(wr_addr) == s) slot_we[s] = 1'b1;
         for (int a = 0; a < AUX_BYTES; a++)
            if (int'(wr_addr) == BANK_SLOTS + a) aux_we[a] = 1'b1;
      end
      if (we && wr_pair) begin
         for (int p = 0; p <= GP_PAIRS; p++) begin
            if (int'(wr_pa) == p) begin
               slot_we[2*p]   = 1'b1;
               slot_we[2*p+1] = 1'b1;
               slot_wd[2*p]   = wr_data[PW-1:DATA_W];
            end
         end
         for (int w = 0; w < WIDE_REGS; w++)
            if (int'(wr_pa) == GP_PAIRS + 1 + w) wide_we[w] = 1'b1;
      end
   end

   // steer slot enables to the bank active before this edge
   always_comb begin
      for (int b = 0; b < NUM_BANKS; b++) begin
         for (int s = 0; s < BANK_SLOTS; s++) begin
            logic alt;
            alt = (s < N_GP) ? (gp_sel == BANK_ALT) : (af_sel == BANK_ALT);
            bank_we[b][s] = slot_we[s] && (alt == (b == 1));
         end
      end
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      rf_bank #(
         .DATA_W (DATA_W),
         .SLOTS  (BANK_SLOTS)
      ) u_bank (
         .clk     (clk),
         .slot_we (bank_we[b]),
         .slot_wd (slot_wd),
         .slot_q  (bank_q[b])
      );
   end

   rf_misc_file #(
      .DATA_W    (DATA_W),
      .AUX_BYTES (AUX_BYTES),
      .WIDE_REGS (WIDE_REGS)
   ) u_misc (
      .clk     (clk),
      .aux_we  (aux_we),
      .aux_wd  (wr_data[DATA_W-1:0]),
      .aux_q   (aux_q),
      .wide_we (wide_we),
      .wide_wd (wr_data),
      .wide_q  (wide_q)
   );

   // active byte view
   always_comb begin
      for (int s = 0; s < BANK_SLOTS; s++) begin
         logic alt;
         alt = (s < N_GP) ? (gp_sel == BANK_ALT) : (af_sel == BANK_ALT);
         act_bytes[s] = alt ? bank_q[1][s] : bank_q[0][s];
      end
      for (int a = 0; a < AUX_BYTES; a++) act_bytes[BANK_SLOTS+a] = aux_q[a];
   end

   // read ports, combinational, unmapped addresses give zero
   always_comb begin
      rd_a_data = '0;
      rd_b_data = '0;
      for (int s = 0; s < BYTE_SLOTS; s++) begin
         if (int'(rd_a_addr) == s) rd_a_data = act_bytes[s];
         if (int'(rd_b_addr) == s) rd_b_data = act_bytes[s];
      end
   end

   always_comb begin
      rd_p_data = '0;
      for (int p = 0; p <= GP_PAIRS; p++)
         if (int'(rd_p_addr) == p) rd_p_data = {act_bytes[2*p], act_bytes[2*p+1]};
      for (int w = 0; w < WIDE_REGS; w++)
         if (int'(rd_p_addr) == GP_PAIRS + 1 + w) rd_p_data = wide_q[w];
   end
endmodule

// File: rtl/rf_dual_bank_chk.sv
module rf_dual_bank_chk
   import rf_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int GP_PAIRS  = 3,
   parameter int AUX_BYTES = 2,
   localparam int BYTE_SLOTS = bank_slots(GP_PAIRS) + AUX_BYTES,
   localparam int BA_W       = $clog2(BYTE_SLOTS),
   localparam int PW         = 2 * DATA_W
) (
   input logic                             clk,
   input logic                             rst,
   input logic                             xchg_gp,
   input logic                             xchg_af,
   input logic                             we,
   input logic                             wr_pair,
   input logic [BA_W-1:0]                  wr_addr,
   input logic [PW-1:0]                    wr_data,
   input logic [BA_W-1:0]                  rd_a_addr,
   input logic [DATA_W-1:0]                rd_a_data,
   input bank_e                            gp_sel,
   input bank_e                            af_sel,
   input logic [BYTE_SLOTS-1:0][DATA_W-1:0] act_bytes
);
   assert_sel_reset_R1: assert property (@(posedge clk)
      rst |=> (gp_sel == BANK_MAIN && af_sel == BANK_MAIN));

   assert_gp_flip_R7: assert property (@(posedge clk) disable iff (rst)
      xchg_gp |=> gp_sel != $past(gp_sel));

   assert_gp_hold_R7: assert property (@(posedge clk) disable iff (rst)
      !xchg_gp |=> $stable(gp_sel));

   assert_af_flip_R8: assert property (@(posedge clk) disable iff (rst)
      xchg_af |=> af_sel != $past(af_sel));

   assert_af_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !xchg_af |=> $stable(af_sel));

   assert_pair_write_R5: assert property (@(posedge clk) disable iff (rst)
      (we && wr_pair && wr_addr == '0 && !xchg_gp) |=>
         (act_bytes[0] == $past(wr_data[PW-1:DATA_W]) &&
          act_bytes[1] == $past(wr_data[DATA_W-1:0])));

   assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
      (!we && !xchg_gp && !xchg_af) |=> $stable(act_bytes));

   assert_unused_zero_R3: assert property (@(posedge clk) disable iff (rst)
      (int'(rd_a_addr) >= BYTE_SLOTS) |-> rd_a_data == '0);
endmodule

bind regfile_dual_bank rf_dual_bank_chk #(
   .DATA_W    (DATA_W),
   .GP_PAIRS  (GP_PAIRS),
   .AUX_BYTES (AUX_BYTES)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .xchg_gp   (xchg_gp),
   .xchg_af   (xchg_af),
   .we        (we),
   .wr_pair   (wr_pair),
   .wr_addr   (wr_addr),
   .wr_data   (wr_data),
   .rd_a_addr (rd_a_addr),
   .rd_a_data (rd_a_data),
   .gp_sel    (gp_sel),
   .af_sel    (af_sel),
   .act_bytes (act_bytes)
);

// File: tb/regfile_dual_bank_tb_top.sv
module regfile_dual_bank_tb_top;
   logic        clk = 1'b0;
   logic        rst;
   logic        xchg_gp, xchg_af, we, wr_pair;
   logic [3:0]  wr_addr, rd_a_addr, rd_b_addr;
   logic [15:0] wr_data, rd_p_data;
   logic [7:0]  rd_a_data, rd_b_data;
   logic [2:0]  rd_p_addr;

   int n_checks = 0;
   int n_fails  = 0;

   // independent model
   logic [7:0]  m_gp  [2][6];
   logic [7:0]  m_af  [2][2];
   logic [7:0]  m_aux [2];
   logic [15:0] m_wide[4];
   int gs = 0;
   int asel = 0;

   always #4 clk = ~clk;   // 125 MHz

   regfile_dual_bank dut_i (
      .clk(clk), .rst(rst), .xchg_gp(xchg_gp), .xchg_af(xchg_af),
      .we(we), .wr_pair(wr_pair), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
      .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
      .rd_p_addr(rd_p_addr), .rd_p_data(rd_p_data)
   );

   function automatic logic [7:0] exp_byte(input int a);
      if (a < 6)       return m_gp[gs][a];
      else if (a < 8)  return m_af[asel][a-6];
      else if (a < 10) return m_aux[a-8];
      return 8'h00;
   endfunction

   function automatic logic [15:0] exp_pair(input int p);
      if (p < 3)  return {m_gp[gs][2*p], m_gp[gs][2*p+1]};
      if (p == 3) return {m_af[asel][0], m_af[asel][1]};
      return m_wide[p-4];
   endfunction

   task automatic check(input string req, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // called at a negedge
   task automatic apply(input bit w, input bit pr, input int ad,
                        input logic [15:0] d, input bit xg, input bit xa);
      we = w; wr_pair = pr; wr_addr = 4'(ad); wr_data = d;
      xchg_gp = xg; xchg_af = xa;
   endtask

   task automatic tick();
      @(posedge clk);
      if (rst) begin
         gs = 0; asel = 0;
      end else begin
         if (we && !wr_pair) begin
            int a = int'(wr_addr);
            if (a < 6)       m_gp[gs][a]     = wr_data[7:0];
            else if (a < 8)  m_af[asel][a-6] = wr_data[7:0];
            else if (a < 10) m_aux[a-8]      = wr_data[7:0];
         end
         if (we && wr_pair) begin
            int p = int'(wr_addr[2:0]);
            if (p < 3) begin
               m_gp[gs][2*p] = wr_data[15:8]; m_gp[gs][2*p+1] = wr_data[7:0];
            end else if (p == 3) begin
               m_af[asel][0] = wr_data[15:8]; m_af[asel][1] = wr_data[7:0];
            end else m_wide[p-4] = wr_data;
         end
         if (xchg_gp) gs = 1 - gs;
         if (xchg_af) asel = 1 - asel;
      end
      @(negedge clk);
      apply(0, 0, 0, 16'h0, 0, 0);
   endtask

   // called with idle inputs; may span idle edges
   task automatic check_all(input string rb, input string rp);
      for (int a = 0; a < 16; a++) begin
         rd_a_addr = 4'(a); rd_b_addr = 4'(15 - a);
         #1;
         check(rb, $sformatf("byte A[%0d]", a), {8'h0, rd_a_data}, {8'h0, exp_byte(a)});
         check(rb, $sformatf("byte B[%0d]", 15 - a), {8'h0, rd_b_data}, {8'h0, exp_byte(15 - a)});
      end
      for (int p = 0; p < 8; p++) begin
         rd_p_addr = 3'(p);
         #1;
         check(rp, $sformatf("pair[%0d]", p), rd_p_data, exp_pair(p));
      end
      @(negedge clk);
   endtask

   task automatic t_init();
      for (int a = 0; a < 10; a++) begin apply(1, 0, a, 16'(8'h10 + a), 0, 0); tick(); end
      for (int p = 4; p < 8; p++) begin apply(1, 1, p, 16'hA000 + 16'(p), 0, 0); tick(); end
      apply(0, 0, 0, 0, 1, 1); tick();
      for (int a = 0; a < 8; a++) begin apply(1, 0, a, 16'(8'h80 + a), 0, 0); tick(); end
      check_all("R2", "R4");
   endtask

   task automatic t_reset_R1();
      rst = 1'b1; tick(); rst = 1'b0;
      check_all("R1", "R1");
   endtask

   task automatic t_pair_write_R5();
      apply(1, 1, 1, 16'hBEEF, 0, 0); tick();
      rd_a_addr = 4'd2; rd_b_addr = 4'd3; #1;
      check("R5", "pair1 high", {8'h0, rd_a_data}, 16'h00BE);
      check("R5", "pair1 low",  {8'h0, rd_b_data}, 16'h00EF);
      apply(1, 1, 3, 16'hC3D4, 0, 0); tick();
      apply(1, 1, 6, 16'h1357, 0, 0); tick();
      check_all("R5", "R5");
   endtask

   task automatic t_partner_R6();
      logic [7:0] hi = m_gp[gs][4];
      apply(1, 0, 5, 16'hFF5A, 0, 0); tick();
      rd_p_addr = 3'd2; #1;
      check("R6", "pair2 after low-byte write", rd_p_data, {hi, 8'h5A});
      check_all("R6", "R6");
   endtask

   task automatic t_unused_R3();
      apply(1, 0, 12, 16'h00EE, 0, 0); tick();
      apply(1, 0, 15, 16'h00EE, 0, 0); tick();
      check_all("R3", "R3");
   endtask

   task automatic t_rdw_R9();
      logic [7:0] old = exp_byte(0);
      apply(1, 0, 0, 16'h0099, 0, 0);
      rd_a_addr = 4'd0; #1;
      check("R9", "read during write", {8'h0, rd_a_data}, {8'h0, old});
      tick();
      rd_a_addr = 4'd0; #1;
      check("R9", "after write", {8'h0, rd_a_data}, 16'h0099);
   endtask

   task automatic t_swap_gp_R7();
      logic [7:0]  o0 = exp_byte(0);
      logic [15:0] op = exp_pair(0);
      apply(0, 0, 0, 0, 1, 0);
      rd_a_addr = 4'd0; rd_p_addr = 3'd0; #1;
      check("R9", "byte in swap cycle", {8'h0, rd_a_data}, {8'h0, o0});
      check("R9", "pair in swap cycle", rd_p_data, op);
      tick();
      check_all("R7", "R7");
   endtask

   task automatic t_swap_af_R8();
      logic [7:0] oa = exp_byte(6);
      apply(0, 0, 0, 0, 0, 1);
      rd_a_addr = 4'd6; #1;
      check("R9", "acc in swap cycle", {8'h0, rd_a_data}, {8'h0, oa});
      tick();
      check_all("R8", "R8");
   endtask

   task automatic t_swap_write_R10();
      apply(1, 0, 1, 16'h0077, 1, 0); tick();
      check_all("R10", "R10");
      apply(0, 0, 0, 0, 1, 0); tick();
      rd_a_addr = 4'd1; #1;
      check("R10", "write landed in old bank", {8'h0, rd_a_data}, 16'h0077);
      check_all("R10", "R10");
   endtask

   task automatic t_idle_R11();
      repeat (5) tick();
      check_all("R11", "R11");
   endtask

   initial begin
      #(8 * 200000);
      n_fails++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

   initial begin
      rst = 1'b1;
      apply(0, 0, 0, 16'h0, 0, 0);
      rd_a_addr = '0; rd_b_addr = '0; rd_p_addr = '0;
      repeat (3) @(negedge clk);
      tick();
      rst = 1'b0;
      t_init();
      t_reset_R1();
      t_pair_write_R5();
      t_partner_R6();
      t_unused_R3();
      t_rdw_R9();
      t_swap_gp_R7();
      t_swap_af_R8();
      t_swap_write_R10();
      t_idle_R11();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end
endmodule